// File: doc/BRIEF.md
# BCD calendar clock with alarm

This block keeps wall-clock time for a chip. It counts seconds, minutes, hours, day of month, month and a two-digit year (2000 to 2099), each held as a packed BCD byte. It also keeps a weekday from 0 to 6. A free-running slow tick enable arrives from a 32.768 kHz source. The block divides that tick down to one advance per second. The time then ripples through the calendar, and month lengths follow the leap-year rule for years divisible by four.

Software reaches every field through a byte-wide register bus. The bus has an address, a write strobe and combinational read data. A run bit in the control register starts and stops the clock. Sticky status bits record the second, minute, hour and day events and an alarm hit. These bits are cleared by writing ones. A busy bit gives warning of the last tick period before each advance, so software can pick a safe moment to access the time. Two interrupt outputs are provided. The alarm line is level-sensitive and masked by an enable bit. The timer line is a one-cycle pulse on each second while its enable bit is set.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0. Control, status and interrupt enable read 0x00, and both interrupt outputs are low.
- R2: The time fields sit at byte offsets seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14 and weekday 0x18. The alarm fields follow the same order from 0x20 to 0x34. Control is at 0x40, status at 0x44 and interrupt enable at 0x48. The alarm fields read back what was written. The interrupt enable register keeps only bit 2 (timer) and bit 3 (alarm).
- R3: Each advance adds one second in packed BCD. Seconds and minutes wrap from 59 to 00 and carry onward. Hours wrap from 23 to 00 and move the day. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months. February has 28 days, or 29 when the year value is divisible by 4 (00 counts). Month 12 wraps to 01, year 99 wraps to 00, and the weekday counts 0 to 6 once per day.
- R4: Status bit 6 (alarm) is set on the advance whose new time equals all six alarm fields exactly. A difference in any single field, the year included, prevents it.
- R5: Status bits 2 to 6 stay set until a status write with a 1 in that bit position. Writing 0 to a bit leaves it unchanged, and other bits are not disturbed.
- R6: The alarm interrupt output is high exactly while status bit 6 and enable bit 3 are both set. The timer interrupt output is high for one clock after each advance while enable bit 2 is set, and it stays low otherwise.
- R7: Status bit 0 (busy) is high during the final tick period of each second while running. Status bit 1 mirrors control bit 0 (run).
- R8: On each advance, status bit 2 is set. Bit 3 is set when the seconds wrap, bit 4 when the minutes wrap, and bit 5 when the hours wrap into a new day.
- R9: With control bit 0 at 0, or with the tick enable low, the time does not change.
- R10: A write to any time or weekday register takes effect on that clock and restarts the sub-second count. The next advance then comes a full second of ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow tick enable, one pulse per oscillator period |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq_alarm | output | 1 | Level alarm interrupt, masked by enable bit 3 |
| irq_timer | output | 1 | One-cycle pulse per second, masked by enable bit 2 |

## Verification
The assertions watch several rules on every clock. An advance happens only inside the busy window. A stopped or tickless divider holds its count, and a time write zeroes it. The time holds steady when there is neither an advance nor a write, and a seconds value of 59 turns into 00. The alarm bit only rises after an advance and stays set until a write clears it. A timer pulse needs its enable. The rest of the behaviour can only be shown by the bench's scenarios: the full BCD ripple across month ends, leap and non-leap Februaries and the century wrap, the exact-match rule for the alarm, the cycle at which busy rises, and the one-second delay after a mid-second time write.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

   typedef logic [7:0] bcd_t;

   localparam int NUM_FIELDS = 6;
   localparam int F_SEC = 0;
   localparam int F_MIN = 1;
   localparam int F_HR  = 2;
   localparam int F_DAY = 3;
   localparam int F_MON = 4;
   localparam int F_YR  = 5;

   typedef bcd_t [NUM_FIELDS-1:0] fields_t;

   // byte offsets; the field order is what software relies on
   localparam int OFS_TIME     = 'h00;
   localparam int OFS_WEEK     = 'h18;
   localparam int OFS_ALARM    = 'h20;
   localparam int OFS_CTRL     = 'h40;
   localparam int OFS_STAT     = 'h44;
   localparam int OFS_INTEN    = 'h48;
   localparam int FIELD_STRIDE = 4;

   // status bit positions
   localparam int ST_BUSY  = 0;
   localparam int ST_RUN   = 1;
   localparam int ST_EVSEC = 2;
   localparam int ST_ALARM = 6;

   // interrupt enable bit positions
   localparam int IE_TIMER = 2;
   localparam int IE_ALARM = 3;

   function automatic bcd_t bcd_inc(input bcd_t v);
      bcd_t r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // tens*10 mod 4 equals tens*2 mod 4, so only the low tens bit matters
   function automatic logic leap_year(input bcd_t yr);
      logic [3:0] s;
      s = yr[3:0] + {2'b00, yr[4], 1'b0};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic bcd_t month_days(input bcd_t mon, input bcd_t yr);
      bcd_t d;
      case (mon)
         8'h02:                      d = leap_year(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
         default:                    d = 8'h31;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
   parameter int TICKS_PER_SEC = 32768,
   parameter int BUSY_TICKS    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic run,
   input  logic restart,
   output logic sec_pulse,
   output logic busy
);

   localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
   localparam logic [CW-1:0] BUSY_FROM = CW'(TICKS_PER_SEC - BUSY_TICKS);

   logic [CW-1:0] cnt;
   logic          at_last;

   assign at_last   = (cnt == LAST);
   assign sec_pulse = tick_en && run && at_last && !restart;
   assign busy      = run && (cnt >= BUSY_FROM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (restart)        cnt <= '0;
      else if (tick_en && run) cnt <= at_last ? '0 : cnt + 1'b1;
   end

   AST_PULSE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |-> busy);                                           // R7
   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick_en && run) && !restart) |=> $stable(cnt));             // R9
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));                                      // R10

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_core_pkg::*;
#(
   parameter bit HAS_WEEKDAY = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adv,
   input  logic [NUM_FIELDS-1:0] wr_field,
   input  logic                  wr_week,
   input  bcd_t                  wdata,
   output fields_t               cur,
   output fields_t               nxt,
   output logic [2:0]            week,
   output logic [2:0]            roll
);

   localparam fields_t RST_VAL = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   bcd_t last_day;
   logic mon_end;
   logic yr_end;

   always_comb begin
      last_day = month_days(cur[F_MON], cur[F_YR]);
      roll[0]  = (cur[F_SEC] >= 8'h59);
      roll[1]  = roll[0] && (cur[F_MIN] >= 8'h59);
      roll[2]  = roll[1] && (cur[F_HR] >= 8'h23);
      mon_end  = roll[2] && (cur[F_DAY] >= last_day);
      yr_end   = mon_end && (cur[F_MON] >= 8'h12);

      nxt[F_SEC] = roll[0] ? 8'h00 : bcd_inc(cur[F_SEC]);
      nxt[F_MIN] = roll[1] ? 8'h00 : (roll[0] ? bcd_inc(cur[F_MIN]) : cur[F_MIN]);
      nxt[F_HR]  = roll[2] ? 8'h00 : (roll[1] ? bcd_inc(cur[F_HR])  : cur[F_HR]);
      nxt[F_DAY] = mon_end ? 8'h01 : (roll[2] ? bcd_inc(cur[F_DAY]) : cur[F_DAY]);
      nxt[F_MON] = yr_end  ? 8'h01 : (mon_end ? bcd_inc(cur[F_MON]) : cur[F_MON]);
      if (yr_end) nxt[F_YR] = (cur[F_YR] >= 8'h99) ? 8'h00 : bcd_inc(cur[F_YR]);
      else        nxt[F_YR] = cur[F_YR];
   end

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cur[i] <= RST_VAL[i];
         else if (wr_field[i]) cur[i] <= wdata;
         else if (adv)         cur[i] <= nxt[i];
      end
   end

   if (HAS_WEEKDAY) begin : g_wk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             week <= 3'd0;
         else if (wr_week)       week <= wdata[2:0];
         else if (adv && roll[2]) week <= (week >= 3'd6) ? 3'd0 : week + 3'd1;
      end
   end else begin : g_nowk
      assign week = 3'd0;
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && (wr_field == '0) && !wr_week) |=> ($stable(cur) && $stable(week))); // R9
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && (cur[F_SEC] == 8'h59)) |=> (cur[F_SEC] == 8'h00));                  // R3

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_core_pkg::*;
(
   input  fields_t cand,
   input  fields_t alarm,
   output logic    hit
);

   logic [NUM_FIELDS-1:0] eq;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_eq
      assign eq[i] = (cand[i] == alarm[i]);
   end

   assign hit = &eq;

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_core_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int BUSY_TICKS    = 1,
   parameter int ADDR_W        = 8,
   parameter bit HAS_WEEKDAY   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_alarm,
   output logic              irq_timer
);

   if (TICKS_PER_SEC < 2) begin : g_chk_tps
      $error("TICKS_PER_SEC must be at least 2");
   end
   if (BUSY_TICKS < 1 || BUSY_TICKS >= TICKS_PER_SEC) begin : g_chk_busy
      $error("BUSY_TICKS must lie in 1..TICKS_PER_SEC-1");
   end
   if (ADDR_W < 8) begin : g_chk_aw
      $error("ADDR_W must cover offsets up to 0x48");
   end

   localparam logic [ADDR_W-1:0] A_WEEK  = ADDR_W'(OFS_WEEK);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_INTEN = ADDR_W'(OFS_INTEN);

   fields_t               cur_time;
   fields_t               nxt_time;
   fields_t               alarm_q;
   logic [2:0]            week;
   logic [2:0]            roll;
   logic [NUM_FIELDS-1:0] wr_field;
   logic [NUM_FIELDS-1:0] wr_alarm;
   logic                  wr_week;
   logic                  restart;
   logic                  sec_pulse;
   logic                  busy;
   logic                  run_q;
   logic                  tmr_en_q;
   logic                  alm_en_q;
   logic [3:0]            ev_q;
   logic                  alarm_st;
   logic                  hit;
   logic                  st_wr;
   logic [7:0]            clr;
   logic [3:0]            ev_set;

   // ---------------- address decode ----------------
   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
      assign wr_field[i] = bus_we && (bus_addr == ADDR_W'(OFS_TIME + i*FIELD_STRIDE));
      assign wr_alarm[i] = bus_we && (bus_addr == ADDR_W'(OFS_ALARM + i*FIELD_STRIDE));
   end
   assign wr_week = bus_we && (bus_addr == A_WEEK);
   assign restart = (|wr_field) || wr_week;
   assign st_wr   = bus_we && (bus_addr == A_STAT);
   assign clr     = st_wr ? bus_wdata : 8'h00;

   // ---------------- datapath ----------------
   rtc_tick_div #(
      .TICKS_PER_SEC (TICKS_PER_SEC),
      .BUSY_TICKS    (BUSY_TICKS)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .run       (run_q),
      .restart   (restart),
      .sec_pulse (sec_pulse),
      .busy      (busy)
   );

   rtc_calendar #(
      .HAS_WEEKDAY (HAS_WEEKDAY)
   ) u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (sec_pulse),
      .wr_field (wr_field),
      .wr_week  (wr_week),
      .wdata    (bus_wdata),
      .cur      (cur_time),
      .nxt      (nxt_time),
      .week     (week),
      .roll     (roll)
   );

   rtc_alarm_match u_match (
      .cand  (nxt_time),
      .alarm (alarm_q),
      .hit   (hit)
   );

   // ---------------- configuration registers ----------------
   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           alarm_q[i] <= 8'h00;
         else if (wr_alarm[i]) alarm_q[i] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         tmr_en_q <= 1'b0;
         alm_en_q <= 1'b0;
      end else begin
         if (bus_we && bus_addr == A_CTRL) run_q <= bus_wdata[0];
         if (bus_we && bus_addr == A_INTEN) begin
            tmr_en_q <= bus_wdata[IE_TIMER];
            alm_en_q <= bus_wdata[IE_ALARM];
         end
      end
   end

   // ---------------- sticky status ----------------
   assign ev_set = {sec_pulse && roll[2], sec_pulse && roll[1],
                    sec_pulse && roll[0], sec_pulse};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q      <= 4'h0;
         alarm_st  <= 1'b0;
         irq_timer <= 1'b0;
      end else begin
         ev_q      <= (ev_q & ~clr[ST_EVSEC +: 4]) | ev_set;
         alarm_st  <= (alarm_st & ~clr[ST_ALARM]) | (sec_pulse && hit);
         irq_timer <= sec_pulse && tmr_en_q;
      end
   end

   assign irq_alarm = alarm_st && alm_en_q;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = 8'h00;
      for (int i = 0; i < NUM_FIELDS; i++) begin
         if (bus_addr == ADDR_W'(OFS_TIME + i*FIELD_STRIDE))  bus_rdata = cur_time[i];
         if (bus_addr == ADDR_W'(OFS_ALARM + i*FIELD_STRIDE)) bus_rdata = alarm_q[i];
      end
      if (bus_addr == A_WEEK)  bus_rdata = {5'b0, week};
      if (bus_addr == A_CTRL)  bus_rdata = {7'b0, run_q};
      if (bus_addr == A_STAT)  bus_rdata = {1'b0, alarm_st, ev_q, run_q, busy};
      if (bus_addr == A_INTEN) bus_rdata = {4'b0, alm_en_q, tmr_en_q, 2'b0};
   end

   AST_ALARM_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_st) |-> $past(sec_pulse));                         // R4
   AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_st && !(st_wr && bus_wdata[ST_ALARM])) |=> alarm_st);   // R5
   AST_TIMER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_timer |-> $past(tmr_en_q));                                // R6
   AST_EVSEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_q[0] && !(st_wr && bus_wdata[ST_EVSEC])) |=> ev_q[0]);     // R8

endmodule

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;

   localparam int CLK_P = 10;
   localparam int TPS   = 8;

   localparam logic [7:0] A_SEC = 8'h00, A_MIN = 8'h04, A_HR = 8'h08, A_DAY = 8'h0C,
                          A_MON = 8'h10, A_YR = 8'h14, A_WK = 8'h18,
                          A_CTRL = 8'h40, A_STAT = 8'h44, A_IE = 8'h48;

   // {yr,mon,day,hr,min,sec,wk} before, then after one second
   localparam logic [111:0] VEC [14] = '{
      112'h24_06_15_10_20_12_03__24_06_15_10_20_13_03,
      112'h24_06_15_10_07_59_03__24_06_15_10_08_00_03,
      112'h24_06_15_09_59_59_03__24_06_15_10_00_00_03,
      112'h24_06_15_23_59_59_03__24_06_16_00_00_00_04,
      112'h24_04_30_23_59_59_02__24_05_01_00_00_00_03,
      112'h24_02_28_23_59_59_03__24_02_29_00_00_00_04,
      112'h24_02_29_23_59_59_04__24_03_01_00_00_00_05,
      112'h23_02_28_23_59_59_02__23_03_01_00_00_00_03,
      112'h99_12_31_23_59_59_06__00_01_01_00_00_00_00,
      112'h00_02_28_23_59_59_01__00_02_29_00_00_00_02,
      112'h24_09_09_23_59_59_01__24_09_10_00_00_00_02,
      112'h24_01_31_23_59_59_05__24_02_01_00_00_00_06,
      112'h24_12_31_23_59_59_02__25_01_01_00_00_00_03,
      112'h19_12_31_23_59_59_06__20_01_01_00_00_00_00
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_alarm;
   logic       irq_timer;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   bcd_rtc_core #(.TICKS_PER_SEC(TPS), .BUSY_TICKS(1)) u_bcd_rtc_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_alarm (irq_alarm),
      .irq_timer (irq_timer)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic load_time(input logic [55:0] t);
      wr(A_YR, t[55:48]); wr(A_MON, t[47:40]); wr(A_DAY, t[39:32]);
      wr(A_HR, t[31:24]); wr(A_MIN, t[23:16]); wr(A_SEC, t[15:8]);
      wr(A_WK, t[7:0]);
   endtask

   task automatic read_time(output logic [55:0] t);
      logic [7:0] v;
      rd(A_YR, v);  t[55:48] = v;
      rd(A_MON, v); t[47:40] = v;
      rd(A_DAY, v); t[39:32] = v;
      rd(A_HR, v);  t[31:24] = v;
      rd(A_MIN, v); t[23:16] = v;
      rd(A_SEC, v); t[15:8]  = v;
      rd(A_WK, v);  t[7:0]   = v;
   endtask

   // the time must have been written just before, so the sub-second count is 0
   task automatic run_one_sec();
      wr(A_CTRL, 8'h01);
      repeat (TPS) @(posedge clk);
      wr(A_CTRL, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [55:0] t;
      logic [7:0]  v;
      int          cnt;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      read_time(t);
      chk("R1 time after reset", 64'(t), 64'h00_01_01_00_00_00_00);
      rd(A_CTRL, v); chk("R1 ctrl", 64'(v), 64'h00);
      rd(A_STAT, v); chk("R1 status", 64'(v), 64'h00);
      rd(A_IE, v);   chk("R1 enables", 64'(v), 64'h00);
      chk("R1 irq lines", {62'b0, irq_alarm, irq_timer}, 64'h0);

      // R2: alarm field readback and enable register masking
      for (int i = 0; i < 6; i++) wr(8'h20 + 8'(i*4), 8'h11 * 8'(i+1));
      for (int i = 0; i < 6; i++) begin
         rd(8'h20 + 8'(i*4), v);
         chk("R2 alarm field readback", 64'(v), 64'(8'h11 * 8'(i+1)));
      end
      wr(A_IE, 8'hFF); rd(A_IE, v); chk("R2 enable bits kept", 64'(v), 64'h0C);
      wr(A_IE, 8'h00);

      // R3: table of rollover cases
      for (int i = 0; i < 14; i++) begin
         load_time(VEC[i][111:56]);
         run_one_sec();
         read_time(t);
         chk($sformatf("R3 vector %0d", i), 64'(t), 64'(VEC[i][55:0]));
      end

      // R7: busy in the last tick period, run bit mirrored
      wr(A_STAT, 8'h7C);
      wr(A_SEC, 8'h00);
      wr(A_CTRL, 8'h01);
      for (int k = 0; k <= TPS; k++) begin
         @(negedge clk);
         bus_addr = A_STAT;
         #1 v = bus_rdata;
         if (k == TPS-2 || k == TPS-1 || k == TPS)
            chk($sformatf("R7 busy/run at tick %0d", k), 64'(v[1:0]),
                (k == TPS-1) ? 64'h3 : 64'h2);
      end
      wr(A_CTRL, 8'h00);

      // R8: event bits
      wr(A_STAT, 8'h7C);
      wr(A_HR, 8'h05); wr(A_MIN, 8'h10); wr(A_SEC, 8'h58);
      run_one_sec();
      rd(A_STAT, v); chk("R8 second event only", 64'(v), 64'h04);
      wr(A_STAT, 8'h7C);
      wr(A_SEC, 8'h59);
      run_one_sec();
      rd(A_STAT, v); chk("R8 minute event", 64'(v), 64'h0C);
      wr(A_STAT, 8'h7C);
      wr(A_HR, 8'h23); wr(A_MIN, 8'h59); wr(A_SEC, 8'h59);
      run_one_sec();
      rd(A_STAT, v); chk("R8 day event", 64'(v), 64'h3C);

      // R4/R5/R6: alarm
      wr(A_STAT, 8'h7C);
      load_time(56'h30_07_04_12_34_55_02);
      wr(8'h20, 8'h56); wr(8'h24, 8'h34); wr(8'h28, 8'h12);
      wr(8'h2C, 8'h04); wr(8'h30, 8'h07); wr(8'h34, 8'h31);
      wr(A_IE, 8'h08);
      wr(A_SEC, 8'h55);
      run_one_sec();
      rd(A_STAT, v); chk("R4 year mismatch no alarm", 64'(v[6]), 64'h0);
      chk("R6 no alarm irq", 64'(irq_alarm), 64'h0);
      wr(8'h34, 8'h30);
      wr(A_SEC, 8'h55);
      run_one_sec();
      rd(A_STAT, v); chk("R4 exact match sets alarm", 64'(v[6]), 64'h1);
      chk("R6 alarm irq high", 64'(irq_alarm), 64'h1);
      wr(A_IE, 8'h00);
      rd(A_STAT, v);
      chk("R6 alarm irq masked", {62'b0, v[6], irq_alarm}, 64'h2);
      wr(A_IE, 8'h08);
      wr(A_STAT, 8'h00);
      rd(A_STAT, v); chk("R5 writing 0 keeps alarm", 64'(v[6]), 64'h1);
      wr(A_SEC, 8'h56);
      run_one_sec();
      rd(A_STAT, v); chk("R5 alarm sticky past match", 64'(v[6]), 64'h1);
      wr(A_STAT, 8'h40);
      rd(A_STAT, v); chk("R5 clears only bit 6", 64'(v), 64'h04);
      chk("R6 irq low after clear", 64'(irq_alarm), 64'h0);

      // R6: timer pulses
      wr(A_IE, 8'h04);
      wr(A_SEC, 8'h00);
      wr(A_CTRL, 8'h01);
      cnt = 0;
      repeat (3*TPS + 1) begin
         @(negedge clk);
         if (irq_timer) cnt++;
      end
      wr(A_CTRL, 8'h00);
      chk("R6 timer pulses in 3 s", 64'(cnt), 64'd3);
      wr(A_IE, 8'h00);
      wr(A_SEC, 8'h00);
      wr(A_CTRL, 8'h01);
      cnt = 0;
      repeat (3*TPS + 1) begin
         @(negedge clk);
         if (irq_timer) cnt++;
      end
      wr(A_CTRL, 8'h00);
      chk("R6 timer masked", 64'(cnt), 64'd0);

      // R9: stopped, and running without ticks
      wr(A_SEC, 8'h10);
      repeat (5*TPS) @(posedge clk);
      rd(A_SEC, v); chk("R9 stopped holds", 64'(v), 64'h10);
      tick_en = 1'b0;
      wr(A_CTRL, 8'h01);
      repeat (5*TPS) @(posedge clk);
      rd(A_SEC, v); chk("R9 no tick holds", 64'(v), 64'h10);
      wr(A_CTRL, 8'h00);
      tick_en = 1'b1;

      // R10: mid-second write restarts the count
      wr(A_SEC, 8'h30);
      wr(A_CTRL, 8'h01);
      repeat (5) @(posedge clk);
      wr(A_SEC, 8'h40);
      for (int k = 0; k <= TPS; k++) begin
         @(negedge clk);
         bus_addr = A_SEC;
         #1 v = bus_rdata;
         if (k == TPS-1 || k == TPS)
            chk($sformatf("R10 seconds at tick %0d", k), 64'(v),
                (k == TPS) ? 64'h41 : 64'h40);
      end
      wr(A_CTRL, 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule